// File: doc/BRIEF.md
# Zero and Stack Page Relocator

This block sits between an 8-bit-class processor's 16-bit address bus and a banked memory of up to four 64 KiB banks. It moves the processor's zero page (0x0000–0x00FF) and its stack page (0x0100–0x01FF) to any page in any bank. Two programmable pointers set the targets. Each pointer has a bank half and a page half. The bank half goes into a shadow register first, and the pointer changes only when its page half is written. A multi-byte update therefore never leaves the pointer in a half-written state.

The translation itself is combinational. A relocated page trades places with its target, so that the page displaced by the relocation stays reachable through the original page-0 or page-1 addresses. Processor addresses 0 and 1 belong to the processor's on-chip port and are flagged rather than translated. When common memory is placed at the bottom of the address space, relocated accesses always land in bank 0. A parameter selects between a four-bank system and a two-bank system. In the two-bank system, bank numbers 2 and 3 fold onto 0 and 1.

Top module: `zp_stack_remap`

## Requirements
- R1: After synchronous reset, the zero-page pointer is page 0x00 in bank 0 and the stack pointer is page 0x01 in bank 0. Each shadow bank is 0. Page-0 and page-1 accesses therefore keep their address and go to bank 0.
- R2: An access to 0x0002–0x00FF leaves with the zero-page pointer's page as its high byte, its own low byte, and the zero-page pointer's bank.
- R3: An access to 0x0100–0x01FF leaves with the stack pointer's page as its high byte, its own low byte, and the stack pointer's bank.
- R4: A write is selected by `wr_sel`:
  - 0 selects the zero-page bank.
  - 1 selects the zero-page page.
  - 2 selects the stack bank.
  - 3 selects the stack page.

  A bank write stores `wr_data[1:0]` in a shadow register only, and the translation does not change. A page write loads `wr_data` as the page and the shadow as the bank, both on the same clock edge.
- R5: Addresses 0x0000 and 0x0001 raise `io_port_hit` and leave untranslated, in the processor bank.
- R6: While `common_bottom` is 1, the bank of a zero-page or stack relocation is 0. The swap match in R7 also uses bank 0 as the pointer bank.
- R7: An access whose high byte equals the zero-page pointer's page, with the processor bank equal to that pointer's effective bank, goes to page 0x00 in the processor bank. If this does not match, the stack pointer is tried in the same way and the access goes to page 0x01. The order of precedence is R5, R2, R3, zero-page swap, stack swap.
- R8: Any other address passes through unchanged, in the processor bank.
- R9: With `FULL_BANKS` = 0, bit 1 of every bank value is cleared before it is used or output. Banks 2 and 3 therefore act as banks 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_bank | input | 2 | Processor bank from the configuration |
| common_bottom | input | 1 | Common memory is placed at the bottom of memory |
| wr_en | input | 1 | Pointer register write strobe |
| wr_sel | input | 2 | Pointer register select (see R4) |
| wr_data | input | 8 | Write data |
| out_bank | output | 2 | Translated bank |
| out_addr | output | 16 | Translated address |
| io_port_hit | output | 1 | Access goes to the processor's on-chip port |

## Verification
The swap path is the hardest case to reach. The processor's high byte must equal a pointer's page, and at the same time the processor bank must equal that pointer's effective bank after the common-memory override and bank folding. Uniform random addresses almost never meet both conditions. The stimulus therefore biases addresses toward pages 0x00, 0x01 and the current pointer targets, draws banks from the small set 0–3, and adds directed cases for a matched swap and an unmatched swap. A second instance with two-bank folding shares the same inputs, so that every stimulus also exercises R9.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

    localparam int ADDR_W = 16;
    localparam int BANK_W = 2;
    localparam int PAGE_W = 8;
    localparam int NUM_PTR = 2;

    typedef enum logic [1:0] {
        SEL_ZP_BANK = 2'd0,
        SEL_ZP_PAGE = 2'd1,
        SEL_SP_BANK = 2'd2,
        SEL_SP_PAGE = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PAGE_W-1:0] page;
    } ptr_t;

    typedef struct packed {
        logic              io;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } xlate_t;

    function automatic logic [BANK_W-1:0] fold_bank(input logic [BANK_W-1:0] b,
                                                    input bit full);
        fold_bank = full ? b : {1'b0, b[0]};
    endfunction

endpackage

// File: rtl/zsr_ptr_reg.sv
module zsr_ptr_reg
    import zsr_pkg::*;
#(
    parameter logic [PAGE_W-1:0] RESET_PAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_we,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] data,
    output ptr_t              active
);

    logic [BANK_W-1:0] shadow_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_bank <= '0;
            active.bank <= '0;
            active.page <= RESET_PAGE;
        end else begin
            if (bank_we) begin
                shadow_bank <= data[BANK_W-1:0];
            end
            if (page_we) begin
                active.page <= data;
                active.bank <= shadow_bank;
            end
        end
    end

    AST_PAGE_COMMITS: assert property (@(posedge clk) disable iff (rst)
        page_we |=> (active.page == $past(data)) && (active.bank == $past(shadow_bank))); // R4

    AST_BANK_ONLY_SHADOW: assert property (@(posedge clk) disable iff (rst)
        (bank_we && !page_we) |=> $stable(active)); // R4

endmodule

// File: rtl/zsr_xlate.sv
module zsr_xlate
    import zsr_pkg::*;
#(
    parameter bit FULL_BANKS = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] cpu_bank,
    input  logic              common_bottom,
    input  ptr_t              zp_ptr,
    input  ptr_t              sp_ptr,
    output xlate_t            result
);

    localparam logic [PAGE_W-1:0] ZP_PAGE = 8'h00;
    localparam logic [PAGE_W-1:0] SP_PAGE = 8'h01;

    logic [BANK_W-1:0] eff_cpu;
    logic [BANK_W-1:0] eff_zp;
    logic [BANK_W-1:0] eff_sp;
    logic [PAGE_W-1:0] hi;
    logic [PAGE_W-1:0] lo;

    always_comb begin
        eff_cpu = fold_bank(cpu_bank, FULL_BANKS);
        eff_zp  = common_bottom ? '0 : fold_bank(zp_ptr.bank, FULL_BANKS);
        eff_sp  = common_bottom ? '0 : fold_bank(sp_ptr.bank, FULL_BANKS);
        hi      = addr[ADDR_W-1:PAGE_W];
        lo      = addr[PAGE_W-1:0];

        result.io   = 1'b0;
        result.bank = eff_cpu;
        result.addr = addr;

        if (addr[ADDR_W-1:1] == '0) begin
            result.io = 1'b1;
        end else if (hi == ZP_PAGE) begin
            result.bank = eff_zp;
            result.addr = {zp_ptr.page, lo};
        end else if (hi == SP_PAGE) begin
            result.bank = eff_sp;
            result.addr = {sp_ptr.page, lo};
        end else if (hi == zp_ptr.page && eff_cpu == eff_zp) begin
            result.addr = {ZP_PAGE, lo};
        end else if (hi == sp_ptr.page && eff_cpu == eff_sp) begin
            result.addr = {SP_PAGE, lo};
        end
    end

endmodule

// File: rtl/zp_stack_remap.sv
module zp_stack_remap
    import zsr_pkg::*;
#(
    parameter bit FULL_BANKS = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [1:0]  cpu_bank,
    input  logic        common_bottom,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic [1:0]  out_bank,
    output logic [15:0] out_addr,
    output logic        io_port_hit
);

    ptr_t   ptrs [NUM_PTR];
    xlate_t res;

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        localparam logic [1:0] BANK_CODE = 2'(2 * i);
        localparam logic [1:0] PAGE_CODE = 2'(2 * i + 1);
        zsr_ptr_reg #(
            .RESET_PAGE(PAGE_W'(i))
        ) u_ptr (
            .clk    (clk),
            .rst    (rst),
            .bank_we(wr_en && wr_sel == BANK_CODE),
            .page_we(wr_en && wr_sel == PAGE_CODE),
            .data   (wr_data),
            .active (ptrs[i])
        );
    end

    zsr_xlate #(
        .FULL_BANKS(FULL_BANKS)
    ) u_xlate (
        .addr         (cpu_addr),
        .cpu_bank     (cpu_bank),
        .common_bottom(common_bottom),
        .zp_ptr       (ptrs[0]),
        .sp_ptr       (ptrs[1]),
        .result       (res)
    );

    assign out_bank    = res.bank;
    assign out_addr    = res.addr;
    assign io_port_hit = res.io;

    AST_PORT_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:1] == '0) |-> (io_port_hit && out_addr == cpu_addr
                                   && out_bank == fold_bank(cpu_bank, FULL_BANKS))); // R5

    AST_COMMON_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (common_bottom && cpu_addr[15:9] == '0 && cpu_addr[15:1] != '0) |-> (out_bank == '0)); // R6

    AST_FOLDED_BANK: assert property (@(posedge clk) disable iff (rst)
        (!FULL_BANKS) |-> (out_bank[1] == 1'b0)); // R9

    AST_LOW_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
        out_addr[7:0] == cpu_addr[7:0]); // R8

endmodule

// File: tb/zp_stack_remap_tb.sv
module zp_stack_remap_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [1:0]  cpu_bank;
    logic        common_bottom;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [7:0]  wr_data;
    logic [1:0]  f_bank, b_bank;
    logic [15:0] f_addr, b_addr;
    logic        f_io, b_io;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0] m_bank [2];
    logic [7:0] m_page [2];
    logic [1:0] m_shadow [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    zp_stack_remap #(.FULL_BANKS(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_bank(cpu_bank),
        .common_bottom(common_bottom), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .out_bank(f_bank), .out_addr(f_addr), .io_port_hit(f_io)
    );

    zp_stack_remap #(.FULL_BANKS(1'b0)) u_dut_base (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_bank(cpu_bank),
        .common_bottom(common_bottom), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .out_bank(b_bank), .out_addr(b_addr), .io_port_hit(b_io)
    );

    function automatic logic [18:0] expect_out(input logic [15:0] a, input logic [1:0] cb,
                                               input logic cm, input bit full);
        logic [1:0] c, z, s;
        c = full ? cb : {1'b0, cb[0]};
        z = cm ? 2'd0 : (full ? m_bank[0] : {1'b0, m_bank[0][0]});
        s = cm ? 2'd0 : (full ? m_bank[1] : {1'b0, m_bank[1][0]});
        if (a < 16'd2)                        return {1'b1, c, a};
        if (a[15:8] == 8'h00)                 return {1'b0, z, m_page[0], a[7:0]};
        if (a[15:8] == 8'h01)                 return {1'b0, s, m_page[1], a[7:0]};
        if (a[15:8] == m_page[0] && c == z)   return {1'b0, c, 8'h00, a[7:0]};
        if (a[15:8] == m_page[1] && c == s)   return {1'b0, c, 8'h01, a[7:0]};
        return {1'b0, c, a};
    endfunction

    task automatic compare(input string req);
        logic [18:0] ef, eb;
        ef = expect_out(cpu_addr, cpu_bank, common_bottom, 1'b1);
        eb = expect_out(cpu_addr, cpu_bank, common_bottom, 1'b0);
        checks++;
        if ({f_io, f_bank, f_addr} !== ef) begin
            fails++;
            $display("FAIL %s full: addr=%h got io=%b bank=%0d addr=%h exp io=%b bank=%0d addr=%h",
                     req, cpu_addr, f_io, f_bank, f_addr, ef[18], ef[17:16], ef[15:0]);
        end
        checks++;
        if ({b_io, b_bank, b_addr} !== eb) begin
            fails++;
            $display("FAIL %s base: addr=%h got io=%b bank=%0d addr=%h exp io=%b bank=%0d addr=%h",
                     req, cpu_addr, b_io, b_bank, b_addr, eb[18], eb[17:16], eb[15:0]);
        end
    endtask

    task automatic probe(input logic [15:0] a, input logic [1:0] cb, input logic cm,
                         input string req);
        @(negedge clk);
        wr_en = 1'b0;
        cpu_addr = a; cpu_bank = cb; common_bottom = cm;
        #1;
        compare(req);
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        case (sel)
            2'd0: m_shadow[0] = d[1:0];
            2'd1: begin m_page[0] = d; m_bank[0] = m_shadow[0]; end
            2'd2: m_shadow[1] = d[1:0];
            default: begin m_page[1] = d; m_bank[1] = m_shadow[1]; end
        endcase
    endtask

    function automatic logic [15:0] pick_addr();
        case ($urandom % 6)
            0: return 16'($urandom % 2);
            1: return {8'h00, 8'($urandom)};
            2: return {8'h01, 8'($urandom)};
            3: return {m_page[0], 8'($urandom)};
            4: return {m_page[1], 8'($urandom)};
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cpu_addr = '0; cpu_bank = '0; common_bottom = 1'b0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        m_bank[0] = 2'd0; m_page[0] = 8'h00; m_shadow[0] = 2'd0;
        m_bank[1] = 2'd0; m_page[1] = 8'h01; m_shadow[1] = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        probe(16'h0050, 2'd2, 1'b0, "R1");
        probe(16'h01C0, 2'd3, 1'b0, "R1");
        probe(16'h0001, 2'd3, 1'b0, "R5");
        probe(16'h0000, 2'd1, 1'b0, "R5");

        write_reg(2'd0, 8'h03);
        probe(16'h0010, 2'd1, 1'b0, "R4");
        write_reg(2'd1, 8'h40);
        probe(16'h0010, 2'd1, 1'b0, "R2");
        probe(16'h4077, 2'd3, 1'b0, "R7");
        probe(16'h4077, 2'd1, 1'b0, "R8");
        probe(16'h0010, 2'd1, 1'b1, "R6");
        probe(16'h4077, 2'd0, 1'b1, "R6");

        write_reg(2'd2, 8'h02);
        probe(16'h01FE, 2'd0, 1'b0, "R4");
        write_reg(2'd3, 8'h80);
        probe(16'h01FE, 2'd0, 1'b0, "R3");
        probe(16'h8033, 2'd2, 1'b0, "R7");
        probe(16'hC123, 2'd3, 1'b0, "R9");

        write_reg(2'd3, 8'h40);
        probe(16'h4012, 2'd3, 1'b0, "R7");
        probe(16'h4012, 2'd2, 1'b0, "R7");

        for (int i = 0; i < 600; i++) begin
            if ($urandom % 5 == 0) begin
                write_reg(2'($urandom), 8'($urandom));
            end else begin
                probe(pick_addr(), 2'($urandom), 1'($urandom % 4 == 0), "R2/R3/R7 random");
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        m_bank[0] = 2'd0; m_page[0] = 8'h00; m_shadow[0] = 2'd0;
        m_bank[1] = 2'd0; m_page[1] = 8'h01; m_shadow[1] = 2'd0;
        probe(16'h00A5, 2'd3, 1'b0, "R1");
        write_reg(2'd1, 8'h22);
        probe(16'h00A5, 2'd3, 1'b0, "R4");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule